// File: doc/BRIEF.md
# Fetch Stall and Delay-Slot Controller

This block decides, every cycle, how many of the decoded instructions presented on its slot lanes enter the instruction window of an out-of-order core that has branch delay slots. Lanes are taken in order. The group ends at the first lane that is not valid, when the window would overflow, or when no free window entry is left. It also ends when an accepted instruction stalls the thread. A pending exception blocks the whole cycle. Translation and instruction-cache responses for the group are judged before the first lane is taken.

The controller keeps the fetch PC and a delay-slot countdown. When the last delay slot after a branch has been taken, it issues a one-cycle resolve request. Branches found inside a delay slot are turned into illegal instructions. System, coprocessor-control, FP-control and store-conditional instructions set sticky stall causes. Translation faults, icache misses and illegal instructions set their own sticky causes. Each cause is cleared by its own bit, and the highest-priority cause is reported as an encoded reason.

Top module: `fetch_stall_ctl`

## Requirements
- R1: Up to FETCH_WIDTH lanes are accepted per cycle, strictly in lane order. Acceptance stops at the first lane whose valid bit is low. `accept_o` is always a contiguous run starting at lane 0.
- R2: Lane i (counting from 0) is accepted only if `win_count_i + i < IWIN_SIZE` and `i < free_count_i`. Later lanes are then refused as well.
- R3: While `exc_pending_i` is high no lane is accepted. If no sticky cause is set, the reason reads OTHER (code 10).
- R4: The PC advances by 4 for each accepted lane and is loaded from `redirect_pc_i` when `redirect_valid_i` is high. It resets to RESET_PC.
- R5: An accepted branch loads the delay count with BRANCH_SLOTS+1, and the count drops by one per accepted lane, the branch included. `ret_pc_o` becomes the branch address plus 4*(BRANCH_SLOTS+1). When the count reaches zero, `resolve_o` pulses, the branch cause (flag bit 0) is set and the group ends. This holds across cycle boundaries.
- R6: A branch accepted while the delay count is nonzero is issued as illegal (`ill_o` for that lane). Any illegal lane (class 6 or converted) sets the exception cause (bit 4) and ends the group.
- R7: Class 2 (system), 3 (coprocessor control), 4 (FP control) and 5 (store-conditional) set causes at bits 5, 6, 1 and 7 respectively and end the group. Classes 2, 3 and 4 also raise `flush_o` for their lane; class 5 does not.
- R8: `ic_refuse_i` refuses the whole group for that cycle only and sets no cause. `ic_miss_i` refuses the group and sets the icache cause (bit 2).
- R9: If the PC has nonzero low two bits, or `itlb_miss_i` is high, the group is refused and the translation cause (bit 3) is set. For the misaligned case, `addr_err_o` also pulses.
- R10: `stall_reason_o` reports causes in this priority: branch (code 1 if `thread_stall_i`, else 2), FP control 3, icache 4, translation 5, exception 6, system 7, coprocessor 8, store-conditional 9. With no cause set it reads 0, or 10 under R3/R8.
- R11: Each cause bit is cleared only by its own `clr_stall_i` bit. `fetch_en_o` is the NOR of all cause bits, and no lane is accepted while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid_i | input | FETCH_WIDTH | Valid bit per decoded lane |
| slot_cls_i | input | 3*FETCH_WIDTH | Class code per lane, lane i in bits 3i+2:3i |
| win_count_i | input | CNT_W | Current window occupancy |
| free_count_i | input | CNT_W | Number of free window entries |
| exc_pending_i | input | 1 | Pending exception, blocks fetch |
| ic_refuse_i | input | 1 | Icache did not take the request this cycle |
| ic_miss_i | input | 1 | Icache miss for the group |
| itlb_miss_i | input | 1 | Translation fault for the group |
| thread_stall_i | input | 1 | Thread-level stall, refines branch reason |
| clr_stall_i | input | 8 | Per-cause clear bits |
| redirect_valid_i | input | 1 | Load PC from redirect_pc_i |
| redirect_pc_i | input | PC_W | Redirect target |
| accept_o | output | FETCH_WIDTH | Lanes accepted this cycle |
| ill_o | output | FETCH_WIDTH | Lane issued as illegal |
| flush_o | output | FETCH_WIDTH | Lane marked to flush |
| resolve_o | output | 1 | Branch resolve request |
| addr_err_o | output | 1 | Misaligned fetch address error |
| pc_o | output | PC_W | Current fetch PC |
| ret_pc_o | output | PC_W | Return PC of last accepted branch |
| fetch_en_o | output | 1 | No sticky cause set |
| stall_flags_o | output | 8 | Sticky cause bits |
| stall_reason_o | output | 4 | Encoded highest-priority stall reason |

## Verification
The bench uses FETCH_WIDTH=4, IWIN_SIZE=16 and BRANCH_SLOTS=1. With four lanes, a branch can sit mid-group so that its single delay slot ends the same group. It can also sit in the last lane, so that the countdown spans a cycle boundary, and a second branch can land exactly in a delay slot. A 16-entry window lets an occupancy of 14 cut a group after two lanes. The free count can then be made the tighter limit on its own.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN  = 3'd0,
        OP_BRANCH = 3'd1,
        OP_SYS    = 3'd2,
        OP_CP0    = 3'd3,
        OP_FPC    = 3'd4,
        OP_SC     = 3'd5,
        OP_ILL    = 3'd6
    } op_cls_e;

    localparam int NFLAG    = 8;
    localparam int F_BRANCH = 0;
    localparam int F_FPC    = 1;
    localparam int F_ICACHE = 2;
    localparam int F_XLATE  = 3;
    localparam int F_EXCEPT = 4;
    localparam int F_SYS    = 5;
    localparam int F_CP0    = 6;
    localparam int F_SC     = 7;

    typedef enum logic [3:0] {
        RSN_NONE   = 4'd0,
        RSN_THREAD = 4'd1,
        RSN_BRANCH = 4'd2,
        RSN_FPC    = 4'd3,
        RSN_ICACHE = 4'd4,
        RSN_XLATE  = 4'd5,
        RSN_EXCEPT = 4'd6,
        RSN_SYS    = 4'd7,
        RSN_CP0    = 4'd8,
        RSN_SC     = 4'd9,
        RSN_OTHER  = 4'd10
    } stall_rsn_e;

    function automatic logic [NFLAG-1:0] cls_cause(op_cls_e c);
        logic [NFLAG-1:0] v;
        v = '0;
        case (c)
            OP_SYS:  v[F_SYS]    = 1'b1;
            OP_CP0:  v[F_CP0]    = 1'b1;
            OP_FPC:  v[F_FPC]    = 1'b1;
            OP_SC:   v[F_SC]     = 1'b1;
            OP_ILL:  v[F_EXCEPT] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic cls_flush(op_cls_e c);
        return (c == OP_SYS) || (c == OP_CP0) || (c == OP_FPC);
    endfunction

endpackage

// File: rtl/fetch_group_seq.sv
module fetch_group_seq
    import fetch_ctl_pkg::*;
#(
    parameter int W     = 4,
    parameter int IWIN  = 16,
    parameter int SLOTS = 1,
    parameter int PC_W  = 32,
    parameter int CNT_W = 5,
    parameter int DLY_W = 2
) (
    input  logic                 go_i,
    input  logic [W-1:0]         valid_i,
    input  op_cls_e              cls_i [W],
    input  logic [CNT_W-1:0]     win_count_i,
    input  logic [CNT_W-1:0]     free_count_i,
    input  logic [PC_W-1:0]      pc_i,
    input  logic [DLY_W-1:0]     dly_i,
    input  logic                 itlb_miss_i,
    input  logic                 ic_miss_i,
    input  logic                 ic_refuse_i,
    output logic [W-1:0]         accept_o,
    output logic [W-1:0]         ill_o,
    output logic [W-1:0]         flush_o,
    output logic [NFLAG-1:0]     set_o,
    output logic [PC_W-1:0]      pc_next_o,
    output logic [DLY_W-1:0]     dly_next_o,
    output logic                 ret_load_o,
    output logic [PC_W-1:0]      ret_val_o,
    output logic                 resolve_o,
    output logic                 addr_err_o
);
    localparam logic [CNT_W:0]  IWIN_L   = (CNT_W+1)'(IWIN);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SLOTS + 1);
    localparam logic [PC_W-1:0] RET_OFS  = PC_W'(4 * (SLOTS + 1));

    logic             run;
    logic [PC_W-1:0]  pc_v;
    logic [DLY_W-1:0] dly_v;
    logic [NFLAG-1:0] now;
    op_cls_e          c;
    logic             misal;

    assign misal = pc_i[1:0] != 2'b00;

    always_comb begin
        accept_o   = '0;
        ill_o      = '0;
        flush_o    = '0;
        set_o      = '0;
        ret_load_o = 1'b0;
        ret_val_o  = '0;
        resolve_o  = 1'b0;
        addr_err_o = 1'b0;
        pc_v       = pc_i;
        dly_v      = dly_i;
        now        = '0;
        c          = OP_PLAIN;
        run        = go_i;
        if (run && valid_i[0] && ({1'b0, win_count_i} < IWIN_L) && (free_count_i != '0)) begin
            if (misal || itlb_miss_i) begin
                set_o[F_XLATE] = 1'b1;
                addr_err_o     = misal;
                run            = 1'b0;
            end else if (ic_miss_i) begin
                set_o[F_ICACHE] = 1'b1;
                run             = 1'b0;
            end else if (ic_refuse_i) begin
                run = 1'b0;
            end
        end
        for (int i = 0; i < W; i++) begin
            if (run) begin
                if (valid_i[i] && (({1'b0, win_count_i} + (CNT_W+1)'(i)) < IWIN_L)
                        && ((CNT_W+1)'(i) < {1'b0, free_count_i})) begin
                    c = cls_i[i];
                    if (c == OP_BRANCH && dly_v != '0) begin
                        c        = OP_ILL;
                        ill_o[i] = 1'b1;
                    end
                    accept_o[i] = 1'b1;
                    if (c == OP_BRANCH) begin
                        dly_v      = DLY_LOAD;
                        ret_load_o = 1'b1;
                        ret_val_o  = pc_v + RET_OFS;
                    end
                    pc_v       = pc_v + PC_W'(4);
                    now        = cls_cause(c);
                    flush_o[i] = cls_flush(c);
                    if (dly_v != '0) begin
                        dly_v = dly_v - 1'b1;
                        if (dly_v == '0) begin
                            resolve_o    = 1'b1;
                            now[F_BRANCH] = 1'b1;
                        end
                    end
                    set_o = set_o | now;
                    if (|now) run = 1'b0;
                end else begin
                    run = 1'b0;
                end
            end
        end
        pc_next_o  = pc_v;
        dly_next_o = dly_v;
    end

endmodule

// File: rtl/stall_cause_bank.sv
module stall_cause_bank
    import fetch_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             fetch_en_o
);
    for (genvar k = 0; k < NFLAG; k++) begin : g_cause
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (set_i[k]) q <= 1'b1;
            else if (clr_i[k]) q <= 1'b0;
        end
        assign flags_o[k] = q;
    end

    assign fetch_en_o = ~|flags_o;

    // R11
    clear_only_own_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0) |=> ((flags_o & ~$past(flags_o)) == '0));

endmodule

// File: rtl/stall_reason_enc.sv
module stall_reason_enc
    import fetch_ctl_pkg::*;
(
    input  logic [NFLAG-1:0] flags_i,
    input  logic             thread_stall_i,
    input  logic             soft_block_i,
    output stall_rsn_e       reason_o
);
    always_comb begin
        if (flags_i[F_BRANCH])      reason_o = thread_stall_i ? RSN_THREAD : RSN_BRANCH;
        else if (flags_i[F_FPC])    reason_o = RSN_FPC;
        else if (flags_i[F_ICACHE]) reason_o = RSN_ICACHE;
        else if (flags_i[F_XLATE])  reason_o = RSN_XLATE;
        else if (flags_i[F_EXCEPT]) reason_o = RSN_EXCEPT;
        else if (flags_i[F_SYS])    reason_o = RSN_SYS;
        else if (flags_i[F_CP0])    reason_o = RSN_CP0;
        else if (flags_i[F_SC])     reason_o = RSN_SC;
        else if (soft_block_i)      reason_o = RSN_OTHER;
        else                        reason_o = RSN_NONE;
    end

    // R10
    none_only_idle_chk: assert final ((reason_o != RSN_NONE) || (flags_i == '0));

endmodule

// File: rtl/fetch_stall_ctl.sv
module fetch_stall_ctl
    import fetch_ctl_pkg::*;
#(
    parameter int FETCH_WIDTH  = 4,
    parameter int IWIN_SIZE    = 16,
    parameter int BRANCH_SLOTS = 1,
    parameter int PC_W         = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int CNT_W = $clog2(IWIN_SIZE + 1),
    localparam int DLY_W = $clog2(BRANCH_SLOTS + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [FETCH_WIDTH-1:0]   slot_valid_i,
    input  logic [3*FETCH_WIDTH-1:0] slot_cls_i,
    input  logic [CNT_W-1:0]         win_count_i,
    input  logic [CNT_W-1:0]         free_count_i,
    input  logic                     exc_pending_i,
    input  logic                     ic_refuse_i,
    input  logic                     ic_miss_i,
    input  logic                     itlb_miss_i,
    input  logic                     thread_stall_i,
    input  logic [7:0]               clr_stall_i,
    input  logic                     redirect_valid_i,
    input  logic [PC_W-1:0]          redirect_pc_i,
    output logic [FETCH_WIDTH-1:0]   accept_o,
    output logic [FETCH_WIDTH-1:0]   ill_o,
    output logic [FETCH_WIDTH-1:0]   flush_o,
    output logic                     resolve_o,
    output logic                     addr_err_o,
    output logic [PC_W-1:0]          pc_o,
    output logic [PC_W-1:0]          ret_pc_o,
    output logic                     fetch_en_o,
    output logic [7:0]               stall_flags_o,
    output logic [3:0]               stall_reason_o
);
    op_cls_e          cls_arr [FETCH_WIDTH];
    logic [PC_W-1:0]  pc_q, pc_nx, ret_q, ret_val;
    logic [DLY_W-1:0] dly_q, dly_nx;
    logic [NFLAG-1:0] set_v, flags;
    logic             ret_load, fen;
    stall_rsn_e       rsn;
    logic [PC_W-1:0]  n_acc;

    for (genvar g = 0; g < FETCH_WIDTH; g++) begin : g_unpack
        assign cls_arr[g] = op_cls_e'(slot_cls_i[3*g +: 3]);
    end

    fetch_group_seq #(
        .W(FETCH_WIDTH), .IWIN(IWIN_SIZE), .SLOTS(BRANCH_SLOTS),
        .PC_W(PC_W), .CNT_W(CNT_W), .DLY_W(DLY_W)
    ) i_seq (
        .go_i(fen && !exc_pending_i), .valid_i(slot_valid_i), .cls_i(cls_arr),
        .win_count_i(win_count_i), .free_count_i(free_count_i),
        .pc_i(pc_q), .dly_i(dly_q), .itlb_miss_i(itlb_miss_i),
        .ic_miss_i(ic_miss_i), .ic_refuse_i(ic_refuse_i),
        .accept_o(accept_o), .ill_o(ill_o), .flush_o(flush_o), .set_o(set_v),
        .pc_next_o(pc_nx), .dly_next_o(dly_nx), .ret_load_o(ret_load),
        .ret_val_o(ret_val), .resolve_o(resolve_o), .addr_err_o(addr_err_o)
    );

    stall_cause_bank i_bank (
        .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_stall_i),
        .flags_o(flags), .fetch_en_o(fen)
    );

    stall_reason_enc i_rsn (
        .flags_i(flags), .thread_stall_i(thread_stall_i),
        .soft_block_i(exc_pending_i || ic_refuse_i), .reason_o(rsn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            dly_q <= '0;
            ret_q <= '0;
        end else begin
            pc_q  <= redirect_valid_i ? redirect_pc_i : pc_nx;
            dly_q <= dly_nx;
            if (ret_load) ret_q <= ret_val;
        end
    end

    always_comb begin
        n_acc = '0;
        for (int i = 0; i < FETCH_WIDTH; i++) n_acc = n_acc + PC_W'(accept_o[i]);
    end

    assign pc_o           = pc_q;
    assign ret_pc_o       = ret_q;
    assign fetch_en_o     = fen;
    assign stall_flags_o  = flags;
    assign stall_reason_o = rsn;

    // R1
    accept_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        ((accept_o + 1'b1) & accept_o) == '0);
    // R3
    exc_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        exc_pending_i |-> accept_o == '0);
    // R11
    stalled_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_en_o |-> accept_o == '0);
    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid_i |=> pc_o == $past(pc_o) + ($past(n_acc) << 2));
    // R5
    resolve_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        resolve_o |=> stall_flags_o[F_BRANCH] && !fetch_en_o);
    // R9
    addr_err_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        addr_err_o |-> accept_o == '0);

endmodule

// File: tb/test_fetch_stall_ctl.sv
`timescale 1ns/1ps
module test_fetch_stall_ctl;
    localparam int W = 4;

    typedef struct {
        logic [3:0] acc;
        logic [3:0] ill;
        logic [3:0] fl;
        logic       res;
        logic       aerr;
        logic [3:0] rsn;
        string      tag;
    } exp_t;

    logic clk = 0, rst = 1;
    logic [3:0]  slot_valid = 0;
    logic [11:0] slot_cls = 0;
    logic [4:0]  win_count = 0, free_count = 16;
    logic exc = 0, icr = 0, icm = 0, itm = 0, tst = 0, rdv = 0;
    logic [7:0]  clr = 0;
    logic [31:0] rdpc = 0;
    logic [3:0]  acc, ill, fl, rsn;
    logic        res, aerr, fen;
    logic [31:0] pc, retpc;
    logic [7:0]  flags;

    int checks = 0, errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    fetch_stall_ctl #(.FETCH_WIDTH(W), .IWIN_SIZE(16), .BRANCH_SLOTS(1)) i_fetch_stall_ctl (
        .clk(clk), .rst(rst), .slot_valid_i(slot_valid), .slot_cls_i(slot_cls),
        .win_count_i(win_count), .free_count_i(free_count), .exc_pending_i(exc),
        .ic_refuse_i(icr), .ic_miss_i(icm), .itlb_miss_i(itm), .thread_stall_i(tst),
        .clr_stall_i(clr), .redirect_valid_i(rdv), .redirect_pc_i(rdpc),
        .accept_o(acc), .ill_o(ill), .flush_o(fl), .resolve_o(res), .addr_err_o(aerr),
        .pc_o(pc), .ret_pc_o(retpc), .fetch_en_o(fen), .stall_flags_o(flags),
        .stall_reason_o(rsn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected group results and compares them mid-cycle
    initial forever begin
        @(negedge clk); #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " accept"}, 32'(acc), 32'(e.acc));
            chk({e.tag, " ill"}, 32'(ill), 32'(e.ill));
            chk({e.tag, " flush"}, 32'(fl), 32'(e.fl));
            chk({e.tag, " resolve"}, 32'(res), 32'(e.res));
            chk({e.tag, " addr_err"}, 32'(aerr), 32'(e.aerr));
            chk({e.tag, " reason"}, 32'(rsn), 32'(e.rsn));
        end
    end

    // driver: side = {itlb, ic_miss, ic_refuse, exc}
    task automatic drive(input logic [3:0] v, input logic [11:0] cls, input logic [4:0] win,
                         input logic [4:0] fr, input logic [3:0] side,
                         input logic [3:0] e_acc, input logic [3:0] e_ill, input logic [3:0] e_fl,
                         input logic e_res, input logic e_aerr, input logic [3:0] e_rsn,
                         input string tag);
        exp_t e;
        @(negedge clk);
        slot_valid = v; slot_cls = cls; win_count = win; free_count = fr;
        exc = side[0]; icr = side[1]; icm = side[2]; itm = side[3];
        clr = 0; rdv = 0;
        e.acc = e_acc; e.ill = e_ill; e.fl = e_fl; e.res = e_res;
        e.aerr = e_aerr; e.rsn = e_rsn; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic post(input string tag, input logic [31:0] e_pc, input logic e_en,
                        input logic [3:0] e_rsn);
        @(posedge clk); #1;
        chk({tag, " pc"}, pc, e_pc);
        chk({tag, " fetch_en"}, 32'(fen), 32'(e_en));
        chk({tag, " reason"}, 32'(rsn), 32'(e_rsn));
    endtask

    task automatic ctl(input logic [7:0] c, input logic rv, input logic [31:0] rp);
        @(negedge clk);
        slot_valid = 0; exc = 0; icr = 0; icm = 0; itm = 0;
        clr = c; rdv = rv; rdpc = rp;
        @(negedge clk);
        clr = 0; rdv = 0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // reset state (R4, R11, R10)
        chk("R4 reset pc", pc, 0);
        chk("R11 reset fetch_en", 32'(fen), 1);
        chk("R10 reset reason", 32'(rsn), 0);

        // R1 full group of plain lanes
        drive(4'hF, 12'h000, 0, 16, 0, 4'hF, 0, 0, 0, 0, 0, "R1 full");
        post("R4 full", 16, 1, 0);
        // R2 window occupancy limit
        drive(4'hF, 12'h000, 14, 16, 0, 4'h3, 0, 0, 0, 0, 0, "R2 window");
        post("R2 window", 24, 1, 0);
        // R2 free-entry limit
        drive(4'hF, 12'h000, 0, 1, 0, 4'h1, 0, 0, 0, 0, 0, "R2 free");
        post("R2 free", 28, 1, 0);
        // R3 pending exception
        drive(4'hF, 12'h000, 0, 16, 4'b0001, 0, 0, 0, 0, 0, 10, "R3 exc");
        post("R3 exc", 28, 1, 10);
        // R8 refuse: one cycle, no cause
        drive(4'hF, 12'h000, 0, 16, 4'b0010, 0, 0, 0, 0, 0, 10, "R8 refuse");
        post("R8 refuse", 28, 1, 10);
        chk("R8 refuse no cause", 32'(flags), 0);
        // R5 branch in lane 1, delay slot in lane 2
        drive(4'hF, 12'h008, 0, 16, 0, 4'h7, 0, 0, 1, 0, 0, "R5 branch");
        post("R5 branch", 40, 0, 2);
        chk("R5 ret pc", retpc, 40);
        chk("R5 branch cause bit0", 32'(flags), 32'h01);
        tst = 1; #1;
        chk("R10 thread over branch", 32'(rsn), 1);
        tst = 0;
        // R11 stalled: nothing accepted
        drive(4'hF, 12'h000, 0, 16, 0, 0, 0, 0, 0, 0, 2, "R11 stalled");
        post("R11 stalled", 40, 0, 2);
        ctl(8'h01, 1, 32'h40);
        chk("R4 redirect", pc, 32'h40);
        chk("R11 cleared", 32'(fen), 1);
        // R6 branch in delay slot becomes illegal
        drive(4'hF, 12'h009, 0, 16, 0, 4'h3, 4'h2, 0, 1, 0, 0, "R6 branch in slot");
        post("R6 branch in slot", 32'h48, 0, 2);
        chk("R6 causes", 32'(flags), 32'h11);
        ctl(8'h01, 0, 0);
        chk("R10 exception after branch", 32'(rsn), 6);
        ctl(8'h10, 0, 0);
        // R7 system
        drive(4'hF, 12'h010, 0, 16, 0, 4'h3, 0, 4'h2, 0, 0, 0, "R7 sys");
        post("R7 sys", 32'h50, 0, 7);
        ctl(8'h40, 0, 0);
        chk("R11 foreign clear keeps sys", 32'(rsn), 7);
        ctl(8'h20, 0, 0);
        // R7 coprocessor control
        drive(4'hF, 12'h018, 0, 16, 0, 4'h3, 0, 4'h2, 0, 0, 0, "R7 cp0");
        post("R7 cp0", 32'h58, 0, 8);
        ctl(8'h40, 0, 0);
        // R7 FP control
        drive(4'hF, 12'h020, 0, 16, 0, 4'h3, 0, 4'h2, 0, 0, 0, "R7 fpc");
        post("R7 fpc", 32'h60, 0, 3);
        ctl(8'h02, 0, 0);
        // R7 store-conditional: no flush
        drive(4'hF, 12'h028, 0, 16, 0, 4'h3, 0, 4'h0, 0, 0, 0, "R7 sc");
        post("R7 sc", 32'h68, 0, 9);
        ctl(8'h80, 0, 0);
        // R8 icache miss
        drive(4'hF, 12'h000, 0, 16, 4'b0100, 0, 0, 0, 0, 0, 0, "R8 miss");
        post("R8 miss", 32'h68, 0, 4);
        ctl(8'h04, 0, 0);
        // R9 translation miss
        drive(4'hF, 12'h000, 0, 16, 4'b1000, 0, 0, 0, 0, 0, 0, "R9 itlb");
        post("R9 itlb", 32'h68, 0, 5);
        ctl(8'h08, 1, 32'h66);
        // R9 misaligned address
        drive(4'hF, 12'h000, 0, 16, 0, 0, 0, 0, 0, 1, 0, "R9 misaligned");
        post("R9 misaligned", 32'h66, 0, 5);
        ctl(8'h08, 1, 32'h80);
        // R6 illegal class in lane 2
        drive(4'hF, 12'h180, 0, 16, 0, 4'h7, 0, 0, 0, 0, 0, "R6 ill input");
        post("R6 ill input", 32'h8C, 0, 6);
        ctl(8'h10, 0, 0);
        // R1 gap in valid bits
        drive(4'b1101, 12'h000, 0, 16, 0, 4'h1, 0, 0, 0, 0, 0, "R1 gap");
        post("R1 gap", 32'h90, 1, 0);
        // R5 branch in last lane, delay slot in next cycle
        drive(4'hF, 12'h200, 0, 16, 0, 4'hF, 0, 0, 0, 0, 0, "R5 cross branch");
        post("R5 cross branch", 32'hA0, 1, 0);
        chk("R5 cross ret pc", retpc, 32'hA4);
        drive(4'hF, 12'h000, 0, 16, 0, 4'h1, 0, 0, 1, 0, 0, "R5 cross slot");
        post("R5 cross slot", 32'hA4, 0, 2);
        ctl(8'h01, 0, 0);
        @(negedge clk); #2;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule